// File: doc/BRIEF.md
# Attribute-Filtered Transaction Event Counter

This block counts transactions seen by a shared-cache snoop queue, and it counts only those that pass a programmable attribute filter. In each cycle it can accept one transaction descriptor. A descriptor carries a valid strobe, the requesting agent, the transaction kind, the snoop outcome and the coherency state of the line, each coded one-hot. It also carries a 2-bit code for the core-module origin. The descriptor is compared against a 64-bit control word. When every attribute in the control word matches, a 40-bit event count advances by one.

Software reaches the block through a small register port. That port has a one-cycle write strobe, an address and a combinational read path. Address 0 holds the control word and address 1 holds the count. The counter stays inert until the upper half of the control word is non-zero. When the count wraps, it sets a sticky overflow flag. Writing the count register clears that flag.

Top module: `snoopq_evt_counter`

## Requirements
- R1: After reset is asserted, reads of address 0 and address 1 both return zero. This covers the control word, the count and the overflow flag.
- R2: While control bits 63:32 are all zero, no descriptor changes the count.
- R3: Control bits 37:32 form the agent mask. A descriptor passes this test only if its one-hot agent shares a set bit with the mask. Bit 37 stands for the central agent, and the value 6'h3F admits every agent.
- R4: Control bits 43:38 form the transaction-kind mask. A descriptor passes only if its one-hot kind shares a set bit with the mask, so 6'h3F admits every kind.
- R5: Control bits 46:44 form the snoop-outcome mask. Bit 44 stands for a clean result, bit 45 for a HIT result and bit 46 for a HITM result. The one-hot snoop input uses the same order (bit 0 clean, bit 1 HIT, bit 2 HITM).
- R6: Control bits 53:47 form the coherency-state mask, with one bit for each of seven states. A descriptor passes only if its one-hot state shares a set bit with the mask.
- R7: Control bit 56 enables the module filter. When bit 56 is set, the descriptor's module code must equal control bits 55:54. When bit 56 is clear, those two bits are ignored. The codes are 01 for the local module, 10 for either of the other modules and 11 for more than one module.
- R8: A cycle with the descriptor valid low never changes the count.
- R9: A count of all ones that takes an increment wraps to zero and sets the overflow flag. The flag then stays set while further events are counted.
- R10: A write to address 1 loads bits 39:0 into the count and clears the overflow flag. In a cycle where a qualifying descriptor arrives together with that write, the write wins.
- R11: A write to address 0 takes effect at the next clock edge. A descriptor that arrives in the same cycle as the write is judged against the old control word.
- R12: A read of address 0 returns the control word. A read of address 1 returns the count in bits 39:0 and the overflow flag in bit 63, with all other bits zero. Addresses 2 and 3 read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 count |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Combinational read data for reg_addr |
| evt_valid | input | 1 | Descriptor valid |
| evt_agent | input | 6 | One-hot requesting agent |
| evt_kind | input | 6 | One-hot transaction kind |
| evt_snoop | input | 3 | One-hot snoop outcome (clean, HIT, HITM) |
| evt_state | input | 7 | One-hot line coherency state |
| evt_module | input | 2 | Core-module origin code |

## Verification
Two pairs of functions can land on the same clock edge.

- **Count write and qualifying descriptor.** The bench issues a count write in the same cycle as a descriptor that would otherwise be counted. It expects the loaded value with no extra increment and with the overflow flag cleared.
- **Control write and descriptor.** The bench replaces an all-admitting control word with one whose agent mask is empty, in the same cycle as a matching descriptor. It expects that descriptor to be counted and the one after it to be dropped.

A behavioural model in the bench mirrors both precedence rules and is compared with the read port on every clock.

// File: rtl/evtc_pkg.sv
package evtc_pkg;
  localparam int CTRL_W   = 64;
  localparam int AGT_LO   = 32;
  localparam int AGT_W    = 6;
  localparam int KND_LO   = 38;
  localparam int KND_W    = 6;
  localparam int SNP_LO   = 44;
  localparam int SNP_W    = 3;
  localparam int STA_LO   = 47;
  localparam int STA_W    = 7;
  localparam int MOD_LO   = 54;
  localparam int MOD_W    = 2;
  localparam int MOD_EN   = 56;
  localparam int ARM_LO   = 32;
  localparam int ADDR_W   = 2;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CNT  = 2'd1;

  typedef struct packed {
    logic [AGT_W-1:0] agent;
    logic [KND_W-1:0] kind;
    logic [SNP_W-1:0] snoop;
    logic [STA_W-1:0] state;
    logic [MOD_W-1:0] module_code;
  } evt_desc_t;
endpackage

// File: rtl/evtc_mask_hit.sv
module evtc_mask_hit #(
  parameter int W = 6
) (
  input  logic [W-1:0] sel,
  input  logic [W-1:0] attr,
  output logic         hit
);
  // One shared set bit between mask and one-hot attribute admits it.
  assign hit = |(sel & attr);
endmodule

// File: rtl/evtc_ctrl_reg.sv
module evtc_ctrl_reg
  import evtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wdata,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              armed
);
  logic [CTRL_W-1:0] ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) ctrl_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctrl_q <= '0;
    else if (wr_en) ctrl_q <= ctrl_d;
  end

  // Counting is live only while the upper half holds something non-zero.
  assign armed = |ctrl_q[CTRL_W-1:ARM_LO];
endmodule

// File: rtl/evtc_filter.sv
module evtc_filter
  import evtc_pkg::*;
(
  input  logic [CTRL_W-1:0] ctrl,
  input  evt_desc_t         desc,
  output logic              all_match
);
  logic agt_hit, knd_hit, snp_hit, sta_hit, mod_hit;

  evtc_mask_hit #(.W(AGT_W)) u_agt (
    .sel(ctrl[AGT_LO +: AGT_W]), .attr(desc.agent), .hit(agt_hit));
  evtc_mask_hit #(.W(KND_W)) u_knd (
    .sel(ctrl[KND_LO +: KND_W]), .attr(desc.kind),  .hit(knd_hit));
  evtc_mask_hit #(.W(SNP_W)) u_snp (
    .sel(ctrl[SNP_LO +: SNP_W]), .attr(desc.snoop), .hit(snp_hit));
  evtc_mask_hit #(.W(STA_W)) u_sta (
    .sel(ctrl[STA_LO +: STA_W]), .attr(desc.state), .hit(sta_hit));

  // Encoded select: compared only when its enable bit is set.
  always_comb begin
    if (ctrl[MOD_EN]) mod_hit = (desc.module_code == ctrl[MOD_LO +: MOD_W]);
    else              mod_hit = 1'b1;
  end

  assign all_match = agt_hit & knd_hit & snp_hit & sta_hit & mod_hit;
endmodule

// File: rtl/evtc_counter.sv
module evtc_counter #(
  parameter int CNT_W = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ovf_q
);
  logic [CNT_W-1:0] cnt_d;
  logic             ovf_d;
  logic             carry;
  logic             en;

  always_comb begin
    cnt_d = cnt_q;
    ovf_d = ovf_q;
    carry = 1'b0;
    if (ld) begin
      cnt_d = ld_val;
      ovf_d = 1'b0;
    end else if (inc) begin
      {carry, cnt_d} = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
      if (carry) ovf_d = 1'b1;
    end
  end

  assign en = ld | inc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (en) begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end
endmodule

// File: rtl/snoopq_evt_counter.sv
module snoopq_evt_counter
  import evtc_pkg::*;
#(
  parameter int CNT_W = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [63:0]       reg_wdata,
  output logic [63:0]       reg_rdata,
  input  logic              evt_valid,
  input  logic [5:0]        evt_agent,
  input  logic [5:0]        evt_kind,
  input  logic [2:0]        evt_snoop,
  input  logic [6:0]        evt_state,
  input  logic [1:0]        evt_module
);
  localparam int OVF_BIT = CTRL_W - 1;

  logic [CTRL_W-1:0] ctrl_q;
  logic              armed;
  logic [CNT_W-1:0]  cnt_q;
  logic              ovf_q;
  logic              all_match;
  logic              ctrl_wr, cnt_wr, cnt_inc;
  evt_desc_t         desc;

  assign desc    = '{agent: evt_agent, kind: evt_kind, snoop: evt_snoop,
                     state: evt_state, module_code: evt_module};
  assign ctrl_wr = reg_wr && (reg_addr == ADDR_CTRL);
  assign cnt_wr  = reg_wr && (reg_addr == ADDR_CNT);
  assign cnt_inc = evt_valid && armed && all_match;

  evtc_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(ctrl_wr), .wdata(reg_wdata),
    .ctrl_q(ctrl_q), .armed(armed));

  evtc_filter u_filt (
    .ctrl(ctrl_q), .desc(desc), .all_match(all_match));

  evtc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(cnt_inc), .ld(cnt_wr),
    .ld_val(reg_wdata[CNT_W-1:0]), .cnt_q(cnt_q), .ovf_q(ovf_q));

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_CTRL: reg_rdata = ctrl_q;
      ADDR_CNT: begin
        reg_rdata[CNT_W-1:0] = cnt_q;
        reg_rdata[OVF_BIT]   = ovf_q;
      end
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/snoopq_evt_counter_chk.sv
module snoopq_evt_counter_chk #(
  parameter int CNT_W = 40
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [1:0]       reg_addr,
  input logic [63:0]      reg_wdata,
  input logic             evt_valid,
  input logic [5:0]       evt_agent,
  input logic [1:0]       evt_module,
  input logic [63:0]      ctrl_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             ovf_q
);
  logic cw, kw;
  assign cw = reg_wr && (reg_addr == 2'd1);
  assign kw = reg_wr && (reg_addr == 2'd0);

  AST_DISARMED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[63:32] == 32'd0 && !cw) |=> ($stable(cnt_q) && $stable(ovf_q))); // R2
  AST_AGENT_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_agent & ctrl_q[37:32]) == 6'd0 && !cw) |=> $stable(cnt_q)); // R3
  AST_MODULE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[56] && evt_module != ctrl_q[55:54] && !cw) |=> $stable(cnt_q)); // R7
  AST_NO_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_valid && !cw) |=> $stable(cnt_q)); // R8
  AST_WRAP_SETS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (!cw && (&cnt_q)) |=> ($stable(cnt_q) || (cnt_q == '0 && ovf_q))); // R9
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !cw) |=> ovf_q); // R9
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cw && !(&cnt_q)) |=> ($stable(cnt_q) || cnt_q == $past(cnt_q) + CNT_W'(1))); // R9
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cw |=> (cnt_q == $past(reg_wdata[CNT_W-1:0]) && !ovf_q)); // R10
  AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    kw |=> (ctrl_q == $past(reg_wdata))); // R11
endmodule

bind snoopq_evt_counter snoopq_evt_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .evt_valid(evt_valid), .evt_agent(evt_agent),
  .evt_module(evt_module), .ctrl_q(ctrl_q), .cnt_q(cnt_q), .ovf_q(ovf_q));

// File: tb/snoopq_evt_counter_bench.sv
module snoopq_evt_counter_bench;
  localparam int CLK_T = 10;
  localparam int CW    = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd1;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        evt_valid = 1'b0;
  logic [5:0]  evt_agent = 6'd1;
  logic [5:0]  evt_kind = 6'd1;
  logic [2:0]  evt_snoop = 3'd1;
  logic [6:0]  evt_state = 7'd1;
  logic [1:0]  evt_module = 2'd1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  snoopq_evt_counter u_snoopq_evt_counter (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_valid(evt_valid),
    .evt_agent(evt_agent), .evt_kind(evt_kind), .evt_snoop(evt_snoop),
    .evt_state(evt_state), .evt_module(evt_module));

  always #(CLK_T/2) clk = ~clk;

  // Behavioural reference model
  longint unsigned m_ctrl, m_cnt;
  bit m_ovf;
  localparam longint unsigned CMASK = (64'd1 << CW) - 64'd1;

  function automatic bit any_common(longint unsigned c, int lo, int w, int attr);
    for (int i = 0; i < w; i++)
      if (((c >> (lo + i)) & 1) == 1 && ((attr >> i) & 1) == 1) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit model_pass(longint unsigned c);
    bit ok;
    ok = any_common(c, 32, 6, int'(evt_agent)) && any_common(c, 38, 6, int'(evt_kind))
      && any_common(c, 44, 3, int'(evt_snoop)) && any_common(c, 47, 7, int'(evt_state));
    if (((c >> 56) & 1) == 1 && ((c >> 54) & 3) != longint'(evt_module)) ok = 1'b0;
    if ((c >> 32) == 0) ok = 1'b0;
    return ok;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 0; m_cnt = 0; m_ovf = 0;
    end else begin
      bit inc;
      inc = evt_valid && model_pass(m_ctrl);
      if (reg_wr && reg_addr == 2'd1) begin
        m_cnt = reg_wdata & CMASK; m_ovf = 0;
      end else if (inc) begin
        if (m_cnt == CMASK) begin m_cnt = 0; m_ovf = 1; end
        else m_cnt = m_cnt + 1;
      end
      if (reg_wr && reg_addr == 2'd0) m_ctrl = reg_wdata;
    end
  end

  function automatic logic [63:0] model_read(logic [1:0] a);
    if (a == 2'd0) return m_ctrl;
    if (a == 2'd1) return {m_ovf, 23'd0, m_cnt[39:0]};
    return 64'd0;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Per-cycle comparison against the model, away from the active edge
  always @(negedge clk)
    if (rst_n && !done) chk("R12 model readback", reg_rdata, model_read(reg_addr));

  task automatic tick(logic v, logic [5:0] a, logic [5:0] k, logic [2:0] s,
                      logic [6:0] st, logic [1:0] m, logic w, logic [1:0] ad,
                      logic [63:0] wd);
    evt_valid = v; evt_agent = a; evt_kind = k; evt_snoop = s;
    evt_state = st; evt_module = m; reg_wr = w; reg_addr = ad; reg_wdata = wd;
    @(posedge clk); #(CLK_T/4);
    evt_valid = 1'b0; reg_wr = 1'b0; reg_addr = 2'd1;
  endtask

  task automatic ev(logic [5:0] a, logic [5:0] k, logic [2:0] s, logic [6:0] st, logic [1:0] m);
    tick(1'b1, a, k, s, st, m, 1'b0, 2'd1, 64'd0);
  endtask

  task automatic wr(logic [1:0] ad, logic [63:0] wd);
    tick(1'b0, 6'd1, 6'd1, 3'd1, 7'd1, 2'd1, 1'b1, ad, wd);
  endtask

  task automatic rd(logic [1:0] ad, output logic [63:0] v);
    reg_addr = ad; #1; v = reg_rdata; reg_addr = 2'd1;
  endtask

  function automatic logic [63:0] mk(logic [5:0] a, logic [5:0] k, logic [2:0] s,
                                     logic [6:0] st, logic [1:0] mc, logic me);
    return {7'd0, me, mc, st, s, k, a, 32'd0};
  endfunction

  localparam logic [63:0] ALL = {7'd0, 1'b0, 2'b00, 7'h7F, 3'h7, 6'h3F, 6'h3F, 32'd0};

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    repeat (3) @(posedge clk);
    #(CLK_T/4); rst_n = 1'b1;
    @(posedge clk); #(CLK_T/4);
    rd(2'd0, v); chk("R1 ctrl after reset", v, 64'd0);
    rd(2'd1, v); chk("R1 count after reset", v, 64'd0);

    // R2: upper half zero, lower half full: never counts
    wr(2'd0, 64'h0000_0000_FFFF_FFFF);
    repeat (5) ev(6'h3F, 6'h3F, 3'h7, 7'h7F, 2'd1);
    rd(2'd1, v); chk("R2 disarmed", v, 64'd0);

    // Arm with all-admitting masks
    wr(2'd0, ALL);
    repeat (4) ev(6'd1, 6'd4, 3'd2, 7'd8, 2'd3);
    rd(2'd1, v); chk("R3 R4 all-admit count", v, 64'd4);
    // R8: valid low
    repeat (3) tick(1'b0, 6'd1, 6'd1, 3'd1, 7'd1, 2'd1, 1'b0, 2'd1, 64'd0);
    rd(2'd1, v); chk("R8 valid low ignored", v, 64'd4);

    // R3 agent
    wr(2'd0, mk(6'h20, 6'h3F, 3'h7, 7'h7F, 2'd0, 1'b0));
    ev(6'h01, 6'd1, 3'd1, 7'd1, 2'd1);
    rd(2'd1, v); chk("R3 agent mismatch", v, 64'd4);
    ev(6'h20, 6'd1, 3'd1, 7'd1, 2'd1);
    rd(2'd1, v); chk("R3 central agent match", v, 64'd5);

    // R4 kind
    wr(2'd0, mk(6'h3F, 6'h02, 3'h7, 7'h7F, 2'd0, 1'b0));
    ev(6'd1, 6'h02, 3'd1, 7'd1, 2'd1);
    ev(6'd1, 6'h04, 3'd1, 7'd1, 2'd1);
    rd(2'd1, v); chk("R4 kind filter", v, 64'd6);

    // R5 snoop: clean only
    wr(2'd0, mk(6'h3F, 6'h3F, 3'b001, 7'h7F, 2'd0, 1'b0));
    ev(6'd1, 6'd1, 3'b001, 7'd1, 2'd1);
    ev(6'd1, 6'd1, 3'b100, 7'd1, 2'd1);
    ev(6'd1, 6'd1, 3'b010, 7'd1, 2'd1);
    rd(2'd1, v); chk("R5 clean only", v, 64'd7);

    // R6 state
    wr(2'd0, mk(6'h3F, 6'h3F, 3'h7, 7'h40, 2'd0, 1'b0));
    ev(6'd1, 6'd1, 3'd1, 7'h40, 2'd1);
    ev(6'd1, 6'd1, 3'd1, 7'h01, 2'd1);
    rd(2'd1, v); chk("R6 state filter", v, 64'd8);

    // R7 module filter enabled with code 10
    wr(2'd0, mk(6'h3F, 6'h3F, 3'h7, 7'h7F, 2'b10, 1'b1));
    ev(6'd1, 6'd1, 3'd1, 7'd1, 2'b10);
    ev(6'd1, 6'd1, 3'd1, 7'd1, 2'b01);
    ev(6'd1, 6'd1, 3'd1, 7'd1, 2'b11);
    rd(2'd1, v); chk("R7 module enabled", v, 64'd9);
    wr(2'd0, mk(6'h3F, 6'h3F, 3'h7, 7'h7F, 2'b10, 1'b0));
    ev(6'd1, 6'd1, 3'd1, 7'd1, 2'b01);
    rd(2'd1, v); chk("R7 module code ignored", v, 64'd10);

    // R10 write collides with qualifying event
    tick(1'b1, 6'd1, 6'd1, 3'd1, 7'd1, 2'd1, 1'b1, 2'd1, 64'd100);
    rd(2'd1, v); chk("R10 write beats event", v, 64'd100);

    // R11 control write collides with event
    wr(2'd0, ALL);
    tick(1'b1, 6'd1, 6'd1, 3'd1, 7'd1, 2'd1, 1'b1, 2'd0,
         mk(6'h00, 6'h3F, 3'h7, 7'h7F, 2'd0, 1'b0));
    rd(2'd1, v); chk("R11 old ctrl applies", v, 64'd101);
    ev(6'd1, 6'd1, 3'd1, 7'd1, 2'd1);
    rd(2'd1, v); chk("R11 new ctrl applies", v, 64'd101);
    rd(2'd0, v); chk("R12 ctrl readback", v, mk(6'h00, 6'h3F, 3'h7, 7'h7F, 2'd0, 1'b0));

    // R9 wrap
    wr(2'd0, ALL);
    wr(2'd1, 64'h0000_00FF_FFFF_FFFE);
    ev(6'd1, 6'd1, 3'd1, 7'd1, 2'd1);
    rd(2'd1, v); chk("R9 near top", v, 64'h0000_00FF_FFFF_FFFF);
    ev(6'd1, 6'd1, 3'd1, 7'd1, 2'd1);
    rd(2'd1, v); chk("R9 wrap sets flag", v, 64'h8000_0000_0000_0000);
    ev(6'd1, 6'd1, 3'd1, 7'd1, 2'd1);
    rd(2'd1, v); chk("R9 flag sticky", v, 64'h8000_0000_0000_0001);
    tick(1'b1, 6'd1, 6'd1, 3'd1, 7'd1, 2'd1, 1'b1, 2'd1, 64'hFFFF_FF00_0000_0005);
    rd(2'd1, v); chk("R10 write clears flag", v, 64'd5);

    // R12 unused addresses
    wr(2'd2, 64'hDEAD_BEEF_0000_0001);
    rd(2'd2, v); chk("R12 addr2 reads zero", v, 64'd0);
    rd(2'd1, v); chk("R12 addr2 write ignored", v, 64'd5);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule